// File: doc/BRIEF.md
# Delayed Read Target

This block sits on the target side of a bus bridge and serves reads by the delayed method. A read strobe that finds no finished data waiting is never completed on the spot. The block answers it with a retry, latches the word address and byte selects, and then reads on the far-side bus by itself. It fetches the requested word and the words after it into a small prefetch store. When the initiator comes back with the same address and selects, the block acknowledges it from that store. An initiator that keeps its cycle open and steps the word address by one on each beat is served the prefetched words back to back.

Only one delayed request is held at a time. It has four states. IDLE holds no request. In FETCH the far-side read sequencer is running. READY means the data is complete and waiting for the initiator. SERVE means a matching burst is in progress. The transitions are:
- IDLE to FETCH when a strobe is captured.
- FETCH to READY when the last prefetch word arrives or the far side answers with an error.
- READY to SERVE when a matching retry is acknowledged.
- READY to IDLE when a matching retry is given an error, or when the discard timer runs out.
- SERVE to IDLE when the initiator drops its cycle.

Any words that were fetched but not used are discarded at that point. All near-side responses are combinational and are given in the cycle of the strobe. Addresses are word addresses.

Top module: `delayed_read_target`

## Requirements
- R1: While reset is high, and in the first cycle after it, tgt_ack, tgt_rty, tgt_err and far_cyc are all low.
- R2: In IDLE, a strobe (tgt_cyc and tgt_stb both high) gets tgt_rty in the same cycle. From the next cycle, far_cyc and far_stb are high, far_adr equals the captured address and far_sel equals the captured selects.
- R3: While a request is held, a strobe whose address or selects differ from the stored ones gets tgt_rty. The held request is not changed, so a later matching retry still returns the data for the stored address.
- R4: The far-side sequencer reads DEPTH consecutive word addresses, starting at the stored address, inside one far cycle. far_sel stays constant, and far_adr steps by one after each far_ack.
- R5: A matching retry that arrives before the far-side read has finished gets tgt_rty and never tgt_ack.
- R6: When the data is complete, a strobe at the stored address with the stored selects gets tgt_ack, and tgt_dat carries the far-side word of that address.
- R7: In the same open cycle, beat k (address equal to the stored address plus k, for k below DEPTH) is acknowledged with the word fetched from that address. A beat at any other address, or with k equal to DEPTH, gets tgt_rty and does not advance the burst.
- R8: When tgt_cyc falls after an acknowledged beat, the held entry and its unused words are discarded. A following read of the same address is retried as a new request.
- R9: If no matching retry arrives within DISCARD_CLKS clocks of the data becoming complete, the entry is discarded. A later read of that address gets tgt_rty.
- R10: An error on the far-side read of the first word is kept with the request. The matching retry gets tgt_err, and the entry is freed.
- R11: An error on a later far-side word k ends the prefetch. Beats 0 to k-1 are acknowledged with data, and beat k gets tgt_rty.
- R12: Each near-side strobe gets exactly one of tgt_ack, tgt_rty and tgt_err. Without a strobe, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tgt_cyc | input | 1 | Initiator cycle in progress |
| tgt_stb | input | 1 | Initiator beat strobe |
| tgt_adr | input | ADDR_W | Initiator word address |
| tgt_sel | input | SEL_W | Initiator byte selects |
| tgt_dat | output | DATA_W | Read data returned with tgt_ack |
| tgt_ack | output | 1 | Beat completed with data |
| tgt_rty | output | 1 | Beat terminated, try again later |
| tgt_err | output | 1 | Beat terminated with error |
| far_cyc | output | 1 | Far-side read cycle in progress |
| far_stb | output | 1 | Far-side beat strobe |
| far_adr | output | ADDR_W | Far-side word address |
| far_sel | output | SEL_W | Far-side byte selects |
| far_dat | input | DATA_W | Far-side read data |
| far_ack | input | 1 | Far-side beat completed |
| far_err | input | 1 | Far-side beat failed |

## Verification
A wrong state shows at the ports in the cycle of the next near-side strobe. An entry that is held when it should have been freed produces tgt_ack where a retry is due. An entry that is lost produces a retry that never ends, so the expected data never appears. A broken sequencer index shows as a far_adr step other than one, or as wrong data on a later burst beat. The bench reads that beat and compares it with the far-side word pattern computed from the address. A stale error flag surfaces as tgt_err on a clean read. A wrong discard count shows as tgt_ack or tgt_rty on the wrong side of the timeout window.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2,
        ST_SERVE = 2'd3
    } dr_state_e;

endpackage

// File: rtl/dr_prefetch_buf.sv
module dr_prefetch_buf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    always_comb begin
        if (rd_idx < IDX_W'(DEPTH)) begin
            rd_data = words[rd_idx[PTR_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/dr_match.sv
module dr_match #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 4,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] req_adr,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] base_adr,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [IDX_W-1:0]  offset,
    output logic              hit
);
    logic [ADDR_W-1:0] want_adr;

    always_comb begin
        want_adr = base_adr + ADDR_W'(offset);
        hit      = (req_adr == want_adr) && (req_sel == base_sel);
    end
endmodule

// File: rtl/dr_discard_timer.sv
module dr_discard_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != CNT_W'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        expire = run && (cnt == CNT_W'(LIMIT - 1));
    end
endmodule

// File: rtl/delayed_read_target.sv
module delayed_read_target #(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int SEL_W        = 4,
    parameter int DEPTH        = 8,
    parameter int DISCARD_CLKS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_cyc,
    input  logic              tgt_stb,
    input  logic [ADDR_W-1:0] tgt_adr,
    input  logic [SEL_W-1:0]  tgt_sel,
    output logic [DATA_W-1:0] tgt_dat,
    output logic              tgt_ack,
    output logic              tgt_rty,
    output logic              tgt_err,
    output logic              far_cyc,
    output logic              far_stb,
    output logic [ADDR_W-1:0] far_adr,
    output logic [SEL_W-1:0]  far_sel,
    input  logic [DATA_W-1:0] far_dat,
    input  logic              far_ack,
    input  logic              far_err
);
    import dr_pkg::*;

    localparam int IDX_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    dr_state_e state, state_nx;

    logic [ADDR_W-1:0] base_adr;
    logic [SEL_W-1:0]  base_sel;
    logic [IDX_W-1:0]  fetch_idx;
    logic [IDX_W-1:0]  fill_cnt;
    logic [IDX_W-1:0]  serve_idx;
    logic              err_flag;

    logic              strobe;
    logic              hit;
    logic              expire;
    logic [IDX_W-1:0]  cmp_off;
    logic [IDX_W-1:0]  rd_idx;
    logic              buf_wr;

    // control decisions made in the output process
    logic do_capture;
    logic do_first;
    logic do_next;

    assign strobe = tgt_cyc && tgt_stb;
    assign cmp_off = (state == ST_SERVE) ? serve_idx : '0;
    assign rd_idx  = (state == ST_SERVE) ? serve_idx : '0;
    assign buf_wr  = (state == ST_FETCH) && far_ack;

    dr_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_match (
        .req_adr  (tgt_adr),
        .req_sel  (tgt_sel),
        .base_adr (base_adr),
        .base_sel (base_sel),
        .offset   (cmp_off),
        .hit      (hit)
    );

    dr_prefetch_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_idx  (fetch_idx),
        .wr_data (far_dat),
        .rd_idx  (rd_idx),
        .rd_data (tgt_dat)
    );

    dr_discard_timer #(.LIMIT(DISCARD_CLKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_READY),
        .expire (expire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx   = state;
        tgt_ack    = 1'b0;
        tgt_rty    = 1'b0;
        tgt_err    = 1'b0;
        do_capture = 1'b0;
        do_first   = 1'b0;
        do_next    = 1'b0;
        far_cyc    = (state == ST_FETCH);
        far_stb    = (state == ST_FETCH);
        far_adr    = base_adr + ADDR_W'(fetch_idx);
        far_sel    = base_sel;
        unique case (state)
            ST_IDLE: begin
                if (strobe) begin
                    tgt_rty    = 1'b1;
                    do_capture = 1'b1;
                    state_nx   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (strobe) begin
                    tgt_rty = 1'b1;
                end
                if (far_err) begin
                    state_nx = ST_READY;
                end else if (far_ack && (fetch_idx == LAST_IDX)) begin
                    state_nx = ST_READY;
                end
            end
            ST_READY: begin
                if (strobe && hit) begin
                    if (err_flag) begin
                        tgt_err  = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        tgt_ack  = 1'b1;
                        do_first = 1'b1;
                        state_nx = ST_SERVE;
                    end
                end else if (strobe) begin
                    tgt_rty = 1'b1;
                end else if (expire) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_SERVE: begin
                if (!tgt_cyc) begin
                    state_nx = ST_IDLE;
                end else if (strobe) begin
                    if (hit && (serve_idx < fill_cnt)) begin
                        tgt_ack = 1'b1;
                        do_next = 1'b1;
                    end else begin
                        tgt_rty = 1'b1;
                    end
                end
            end
        endcase
    end

    // request and sequencer registers
    always_ff @(posedge clk) begin
        if (rst) begin
            base_adr  <= '0;
            base_sel  <= '0;
            fetch_idx <= '0;
            fill_cnt  <= '0;
            serve_idx <= '0;
            err_flag  <= 1'b0;
        end else begin
            if (do_capture) begin
                base_adr  <= tgt_adr;
                base_sel  <= tgt_sel;
                fetch_idx <= '0;
                fill_cnt  <= '0;
                err_flag  <= 1'b0;
            end
            if (state == ST_FETCH) begin
                if (far_err) begin
                    err_flag <= (fetch_idx == '0);
                end else if (far_ack) begin
                    fetch_idx <= fetch_idx + 1'b1;
                    fill_cnt  <= fetch_idx + 1'b1;
                end
            end
            if (do_first) begin
                serve_idx <= IDX_W'(1);
            end else if (do_next) begin
                serve_idx <= serve_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tgt_cyc,
    input logic              tgt_stb,
    input logic [ADDR_W-1:0] tgt_adr,
    input logic [SEL_W-1:0]  tgt_sel,
    input logic              tgt_ack,
    input logic              tgt_rty,
    input logic              tgt_err,
    input logic              far_cyc,
    input logic              far_stb,
    input logic [ADDR_W-1:0] far_adr,
    input logic [SEL_W-1:0]  far_sel,
    input logic              far_ack,
    input dr_pkg::dr_state_e st
);
    import dr_pkg::*;

    logic strobe;
    assign strobe = tgt_cyc && tgt_stb;

    p_one_resp_r12: assert property (@(posedge clk) disable iff (rst)
        strobe |-> ($countones({tgt_ack, tgt_rty, tgt_err}) == 1));

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> !(tgt_ack || tgt_rty || tgt_err));

    p_idle_retry_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && strobe) |-> tgt_rty);

    p_fetch_start_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && strobe) |=>
            (far_cyc && far_stb && far_adr == $past(tgt_adr) && far_sel == $past(tgt_sel)));

    p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (far_cyc && $past(far_cyc)) |-> $stable(far_sel));

    p_adr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (far_cyc && $past(far_cyc && far_ack)) |-> (far_adr == $past(far_adr) + ADDR_W'(1)));

    p_no_ack_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH) |-> !tgt_ack);

    p_drop_free_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SERVE && !tgt_cyc) |=> (st == ST_IDLE));
endmodule

bind delayed_read_target dr_checker #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tgt_cyc (tgt_cyc),
    .tgt_stb (tgt_stb),
    .tgt_adr (tgt_adr),
    .tgt_sel (tgt_sel),
    .tgt_ack (tgt_ack),
    .tgt_rty (tgt_rty),
    .tgt_err (tgt_err),
    .far_cyc (far_cyc),
    .far_stb (far_stb),
    .far_adr (far_adr),
    .far_sel (far_sel),
    .far_ack (far_ack),
    .st      (state)
);

// File: tb/delayed_read_target_bench.sv
`timescale 1ns/1ps
module delayed_read_target_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = 4;
    localparam int DEP = 8;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tgt_cyc = 1'b0, tgt_stb = 1'b0;
    logic [AW-1:0] tgt_adr = '0;
    logic [SW-1:0] tgt_sel = '0;
    logic [DW-1:0] tgt_dat;
    logic tgt_ack, tgt_rty, tgt_err;
    logic far_cyc, far_stb;
    logic [AW-1:0] far_adr;
    logic [SW-1:0] far_sel;
    logic [DW-1:0] far_dat = '0;
    logic far_ack = 1'b0, far_err = 1'b0;

    logic err_en = 1'b0;
    logic [AW-1:0] err_adr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    delayed_read_target #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(SW),
                          .DEPTH(DEP), .DISCARD_CLKS(TMO)) u_delayed_read_target (
        .clk(clk), .rst(rst),
        .tgt_cyc(tgt_cyc), .tgt_stb(tgt_stb), .tgt_adr(tgt_adr), .tgt_sel(tgt_sel),
        .tgt_dat(tgt_dat), .tgt_ack(tgt_ack), .tgt_rty(tgt_rty), .tgt_err(tgt_err),
        .far_cyc(far_cyc), .far_stb(far_stb), .far_adr(far_adr), .far_sel(far_sel),
        .far_dat(far_dat), .far_ack(far_ack), .far_err(far_err)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    // far-side memory model: one wait cycle per beat
    always @(posedge clk) begin
        if (rst) begin
            far_ack <= 1'b0;
            far_err <= 1'b0;
        end else if (far_cyc && far_stb && !far_ack && !far_err) begin
            if (err_en && far_adr == err_adr) begin
                far_err <= 1'b1;
            end else begin
                far_ack <= 1'b1;
                far_dat <= pat(far_adr);
            end
        end else begin
            far_ack <= 1'b0;
            far_err <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // resp code: 1 ack, 2 rty, 4 err
    task automatic beat(input logic [AW-1:0] a, input logic [SW-1:0] s,
                        output logic [2:0] resp, output logic [DW-1:0] d);
        @(negedge clk);
        tgt_cyc = 1'b1; tgt_stb = 1'b1; tgt_adr = a; tgt_sel = s;
        #1;
        resp = {tgt_err, tgt_rty, tgt_ack};
        d = tgt_dat;
    endtask

    task automatic end_cyc();
        @(negedge clk);
        tgt_cyc = 1'b0; tgt_stb = 1'b0;
    endtask

    task automatic single(input logic [AW-1:0] a, input logic [SW-1:0] s,
                          output logic [2:0] resp, output logic [DW-1:0] d);
        beat(a, s, resp, d);
        end_cyc();
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    // serve a held request and close it so the block returns to idle
    task automatic drain(input logic [AW-1:0] a, input logic [SW-1:0] s);
        logic [2:0] r; logic [DW-1:0] d;
        wait_clks(40);
        single(a, s, r, d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!tgt_ack && !tgt_rty && !tgt_err && !far_cyc, "R1 in reset",
            {tgt_ack, tgt_rty, tgt_err, far_cyc}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tgt_ack && !tgt_rty && !tgt_err && !far_cyc, "R1 after reset",
            {tgt_ack, tgt_rty, tgt_err, far_cyc}, 0);
    endtask

    task automatic t_basic();
        logic [2:0] r; logic [DW-1:0] d;
        beat(16'h0100, 4'hF, r, d);
        chk(r == 3'b010, "R2 first attempt retried", r, 3'b010);
        @(negedge clk);
        tgt_cyc = 1'b0; tgt_stb = 1'b0;
        chk(far_cyc && far_stb && far_adr == 16'h0100 && far_sel == 4'hF,
            "R2 far read starts", {far_cyc, far_adr}, {1'b1, 16'h0100});
        single(16'h0100, 4'hF, r, d);
        chk(r == 3'b010, "R5 early retry", r, 3'b010);
        wait_clks(40);
        single(16'h0100, 4'hF, r, d);
        chk(r == 3'b001, "R6 ack on ready", r, 3'b001);
        chk(d == pat(16'h0100), "R6 data", d, pat(16'h0100));
        single(16'h0100, 4'hF, r, d);
        chk(r == 3'b010, "R8 entry freed after cycle end", r, 3'b010);
        drain(16'h0100, 4'hF);
    endtask

    task automatic t_burst();
        logic [2:0] r; logic [DW-1:0] d;
        single(16'h2000, 4'h3, r, d);
        wait_clks(40);
        for (int k = 0; k < 2; k++) begin
            beat(16'h2000 + AW'(k), 4'h3, r, d);
            chk(r == 3'b001 && d == pat(16'h2000 + AW'(k)), "R7 burst beat", d,
                pat(16'h2000 + AW'(k)));
        end
        beat(16'h2005, 4'h3, r, d);
        chk(r == 3'b010, "R7 out of sequence beat retried", r, 3'b010);
        for (int k = 2; k < DEP; k++) begin
            beat(16'h2000 + AW'(k), 4'h3, r, d);
            chk(r == 3'b001 && d == pat(16'h2000 + AW'(k)), "R7 burst beat", d,
                pat(16'h2000 + AW'(k)));
        end
        beat(16'h2000 + AW'(DEP), 4'h3, r, d);
        chk(r == 3'b010, "R7 beat past depth retried", r, 3'b010);
        end_cyc();
        single(16'h2003, 4'h3, r, d);
        chk(r == 3'b010, "R8 unused words discarded", r, 3'b010);
        drain(16'h2003, 4'h3);
    endtask

    task automatic t_other();
        logic [2:0] r; logic [DW-1:0] d;
        single(16'h0400, 4'hF, r, d);
        wait_clks(40);
        single(16'h0777, 4'hF, r, d);
        chk(r == 3'b010, "R3 other address retried", r, 3'b010);
        single(16'h0400, 4'h1, r, d);
        chk(r == 3'b010, "R3 other selects retried", r, 3'b010);
        single(16'h0400, 4'hF, r, d);
        chk(r == 3'b001 && d == pat(16'h0400), "R3 held request kept", d, pat(16'h0400));
    endtask

    task automatic t_timeout();
        logic [2:0] r; logic [DW-1:0] d;
        single(16'h0500, 4'hF, r, d);
        wait_clks(16 + TMO - 12);
        single(16'h0500, 4'hF, r, d);
        chk(r == 3'b001, "R9 served inside window", r, 3'b001);
        single(16'h0600, 4'hF, r, d);
        wait_clks(16 + TMO + 12);
        single(16'h0600, 4'hF, r, d);
        chk(r == 3'b010, "R9 discarded after window", r, 3'b010);
        drain(16'h0600, 4'hF);
    endtask

    task automatic t_errors();
        logic [2:0] r; logic [DW-1:0] d;
        err_en = 1'b1; err_adr = 16'h0800;
        single(16'h0800, 4'hF, r, d);
        wait_clks(40);
        single(16'h0800, 4'hF, r, d);
        chk(r == 3'b100, "R10 first word error returned", r, 3'b100);
        err_en = 1'b0;
        single(16'h0800, 4'hF, r, d);
        chk(r == 3'b010, "R10 entry freed after error", r, 3'b010);
        drain(16'h0800, 4'hF);
        err_en = 1'b1; err_adr = 16'h0903;
        single(16'h0900, 4'hF, r, d);
        wait_clks(40);
        for (int k = 0; k < 3; k++) begin
            beat(16'h0900 + AW'(k), 4'hF, r, d);
            chk(r == 3'b001 && d == pat(16'h0900 + AW'(k)), "R11 words before error",
                d, pat(16'h0900 + AW'(k)));
        end
        beat(16'h0903, 4'hF, r, d);
        chk(r == 3'b010, "R11 failed word retried", r, 3'b010);
        end_cyc();
        err_en = 1'b0;
    endtask

    task automatic t_quiet();
        @(negedge clk);
        tgt_cyc = 1'b1; tgt_stb = 1'b0;
        #1;
        chk(!tgt_ack && !tgt_rty && !tgt_err, "R12 no response without strobe",
            {tgt_ack, tgt_rty, tgt_err}, 0);
        end_cyc();
    endtask

    initial begin
        wait_clks(3);
        t_reset();
        t_basic();
        t_burst();
        t_other();
        t_timeout();
        t_errors();
        t_quiet();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule